// File: doc/BRIEF.md
# Predicated Three-Way Byte Deinterleaving Load Unit

This block takes a packed stream of byte triples from memory and splits it across three vector registers. Triple number k feeds element k of each destination: its lowest-addressed byte goes to the first vector, the middle byte to the second, and the highest byte to the third. A per-element predicate mask chooses which triples are fetched. Each active element costs three single-byte reads. An inactive element costs none, cannot fault, and reads back as zero in all three vectors.

A job is launched through a start handshake that carries a base address, a small signed immediate and the predicate mask. The immediate is scaled by the number of byte elements in one vector, so it steps in whole-vector units. Reads go out one byte at a time over a request/response port that has an error flag. A job ends in one of three ways. It can complete, updating all three vectors together and pulsing done. A read error can stop it, pulsing fault with the failing element index. An illegal immediate can refuse it, pulsing reject.

Top module: `tri_deint_load`

## Requirements
- R1: Element k occupies bits [8k+7:8k] of each output vector. The byte at group offset 0 lands in `vec_a`, offset 1 in `vec_b` and offset 2 in `vec_c`.
- R2: The byte address for group k, offset j (0..2), is base + imm*(VL_BITS/8) + 3k + j, computed modulo 2^ADDR_W with imm sign-extended.
- R3: An element whose predicate bit is 0 issues no memory request, and its byte in all three output vectors is zero after completion.
- R4: An inactive element never causes a fault, even when every one of its addresses would return an error.
- R5: Requests go in ascending element order and, within an element, in ascending address order. Only one request is outstanding at a time. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.
- R6: An error response on any read stops the job. The unit then pulses `fault` for one cycle with `fault_idx` set to the element index, issues no further request, and leaves all three output vectors at their values from before the start.
- R7: On normal completion all three vectors change in the same cycle as a one-cycle `done` pulse. The vectors never change in any other cycle.
- R8: An all-zero predicate completes with `done`, issues no memory traffic and produces all-zero vectors.
- R9: An immediate that is not a multiple of 3 or lies outside -24..21 is refused. The unit pulses `reject` for one cycle, issues no request, leaves the vectors unchanged and returns to idle.
- R10: After reset, `start_ready` is high, `done`, `fault`, `reject` and `mem_req_valid` are low, and all vectors are zero. `start_ready` is high only while no job is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request |
| start_ready | output | 1 | Unit idle, start accepted this cycle if valid |
| start_base | input | ADDR_W | Base byte address |
| start_imm | input | 6 | Signed immediate in whole-vector units |
| start_pred | input | VL_BITS/8 | Per-element predicate, bit k for element k |
| mem_req_valid | output | 1 | Byte read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Byte address of the request |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | 8 | Returned byte |
| mem_rsp_err | input | 1 | Response carries an error |
| vec_a | output | VL_BITS | First destination vector |
| vec_b | output | VL_BITS | Second destination vector |
| vec_c | output | VL_BITS | Third destination vector |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_idx | output | log2(VL_BITS/8) | Element index of the last fault |
| reject | output | 1 | One-cycle pulse for a refused immediate |

## Verification
The assertions assume the memory side behaves. A response arrives only while a request is outstanding, and `mem_req_ready` is only a per-cycle acceptance with no memory of earlier cycles. The testbench memory model respects this. It answers exactly one cycle after each acceptance and withholds ready on a fixed stall pattern, so the unit's hold behaviour is exercised. Start is raised only while `start_ready` is high, and the test cases pick base addresses so that a known boundary splits the error region from readable memory. This makes inactive elements sit on error addresses while active ones do not, and shows which element faults.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int IMM_W = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_WAIT,
    ST_COMMIT
  } tdl_state_t;
endpackage

// File: rtl/tdl_addr_gen.sv
module tdl_addr_gen import tdl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_load,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  lane,
  input  logic [1:0]        bsel,
  output logic [ADDR_W-1:0] addr,
  output logic              imm_ok
);
  localparam int LG_LANES = $clog2(LANES);

  function automatic logic imm_legal(input logic [IMM_W-1:0] v);
    int iv;
    iv = int'($signed(v));
    return (iv >= -24) && (iv <= 21) && ((iv % 3) == 0);
  endfunction

  function automatic logic [ADDR_W-1:0] origin(input logic [ADDR_W-1:0] b,
                                               input logic [IMM_W-1:0] v);
    logic [ADDR_W-1:0] sx;
    sx = {{(ADDR_W-IMM_W){v[IMM_W-1]}}, v};
    return b + (sx << LG_LANES);
  endfunction

  function automatic logic [ADDR_W-1:0] offset(input logic [IDX_W-1:0] k,
                                               input logic [1:0] j);
    logic [ADDR_W-1:0] kk;
    kk = {{(ADDR_W-IDX_W){1'b0}}, k};
    return (kk << 1) + kk + {{(ADDR_W-2){1'b0}}, j};
  endfunction

  logic [ADDR_W-1:0] origin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) origin_q <= '0;
    else if (grp_load) origin_q <= origin(base, imm);
  end

  assign imm_ok = imm_legal(imm);
  assign addr   = origin_q + offset(lane, bsel);
endmodule

// File: rtl/tdl_stage.sv
module tdl_stage #(
  parameter int VL_BITS = 128,
  parameter int LANES   = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [IDX_W-1:0]   wr_lane,
  input  logic [7:0]         wr_data,
  output logic [2:0][VL_BITS-1:0] planes
);
  for (genvar p = 0; p < 3; p++) begin : g_plane
    logic [VL_BITS-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (clear) q <= '0;
      else if (wr_en && (wr_sel == 2'(p))) q[wr_lane*8 +: 8] <= wr_data;
    end
    assign planes[p] = q;
  end
endmodule

// File: rtl/tdl_ctrl.sv
module tdl_ctrl import tdl_pkg::*; #(
  parameter int LANES = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic             imm_ok,
  input  logic [LANES-1:0] pred,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             mem_rsp_err,
  output logic             start_ready,
  output logic             grp_load,
  output logic [IDX_W-1:0] lane,
  output logic [1:0]       bsel,
  output logic             mem_req_valid,
  output logic             wr_en,
  output logic             commit_evt,
  output logic             fault_evt,
  output logic             reject_evt
);
  tdl_state_t       state_q, state_d;
  logic [IDX_W-1:0] lane_q, lane_d;
  logic [1:0]       bsel_q, bsel_d;
  logic [LANES-1:0] pred_q;

  wire accept  = start_valid && (state_q == ST_IDLE);
  wire is_last = (lane_q == IDX_W'(LANES-1));

  always_comb begin
    state_d    = state_q;
    lane_d     = lane_q;
    bsel_d     = bsel_q;
    grp_load   = 1'b0;
    wr_en      = 1'b0;
    commit_evt = 1'b0;
    fault_evt  = 1'b0;
    reject_evt = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (imm_ok) begin
          grp_load = 1'b1;
          lane_d   = '0;
          bsel_d   = '0;
          state_d  = ST_SCAN;
        end else begin
          reject_evt = 1'b1;
        end
      end
      ST_SCAN: begin
        if (pred_q[lane_q]) begin
          bsel_d  = '0;
          state_d = ST_REQ;
        end else if (is_last) begin
          state_d = ST_COMMIT;
        end else begin
          lane_d = lane_q + 1'b1;
        end
      end
      ST_REQ: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          fault_evt = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          wr_en = 1'b1;
          if (bsel_q == 2'd2) begin
            bsel_d = '0;
            if (is_last) state_d = ST_COMMIT;
            else begin
              lane_d  = lane_q + 1'b1;
              state_d = ST_SCAN;
            end
          end else begin
            bsel_d  = bsel_q + 1'b1;
            state_d = ST_REQ;
          end
        end
      end
      ST_COMMIT: begin
        commit_evt = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      bsel_q  <= '0;
      pred_q  <= '0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      bsel_q  <= bsel_d;
      if (grp_load) pred_q <= pred;
    end
  end

  assign start_ready   = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign lane          = lane_q;
  assign bsel          = bsel_q;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid);

  // R3
  active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> pred_q[lane_q]);

  // R6
  stop_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !mem_req_valid && start_ready);

  // R9
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> start_ready && !mem_req_valid);
endmodule

// File: rtl/tri_deint_load.sv
module tri_deint_load import tdl_pkg::*; #(
  parameter int VL_BITS = 128,
  parameter int ADDR_W  = 32,
  localparam int LANES  = VL_BITS / 8,
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [ADDR_W-1:0]  start_base,
  input  logic [5:0]         start_imm,
  input  logic [LANES-1:0]   start_pred,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [7:0]         mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic [VL_BITS-1:0] vec_a,
  output logic [VL_BITS-1:0] vec_b,
  output logic [VL_BITS-1:0] vec_c,
  output logic               done,
  output logic               fault,
  output logic [IDX_W-1:0]   fault_idx,
  output logic               reject
);
  logic                     grp_load, imm_ok, wr_en;
  logic                     commit_evt, fault_evt, reject_evt;
  logic [IDX_W-1:0]         lane;
  logic [1:0]               bsel;
  logic [2:0][VL_BITS-1:0]  planes;

  tdl_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .imm_ok(imm_ok),
    .pred(start_pred), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .start_ready(start_ready), .grp_load(grp_load), .lane(lane), .bsel(bsel),
    .mem_req_valid(mem_req_valid), .wr_en(wr_en), .commit_evt(commit_evt),
    .fault_evt(fault_evt), .reject_evt(reject_evt)
  );

  tdl_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .grp_load(grp_load), .base(start_base),
    .imm(start_imm), .lane(lane), .bsel(bsel), .addr(mem_req_addr),
    .imm_ok(imm_ok)
  );

  tdl_stage #(.VL_BITS(VL_BITS), .LANES(LANES), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .clear(grp_load), .wr_en(wr_en),
    .wr_sel(bsel), .wr_lane(lane), .wr_data(mem_rsp_data), .planes(planes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_a     <= '0;
      vec_b     <= '0;
      vec_c     <= '0;
      done      <= 1'b0;
      fault     <= 1'b0;
      fault_idx <= '0;
      reject    <= 1'b0;
    end else begin
      done   <= commit_evt;
      fault  <= fault_evt;
      reject <= reject_evt;
      if (fault_evt) fault_idx <= lane;
      if (commit_evt) begin
        vec_a <= planes[0];
        vec_b <= planes[1];
        vec_c <= planes[2];
      end
    end
  end

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(vec_a) && $stable(vec_b) && $stable(vec_c));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, fault, reject}) <= 1);

  // R10
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !start_ready);
endmodule

// File: tb/tri_deint_load_test.sv
module tri_deint_load_test;
  localparam int CLK_PERIOD = 10;
  localparam int VL = 128;
  localparam int AW = 32;
  localparam int LANES = VL / 8;
  localparam int IW = $clog2(LANES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [AW-1:0] start_base = '0;
  logic [5:0] start_imm = '0;
  logic [LANES-1:0] start_pred = '0;
  logic mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid, mem_rsp_err;
  logic [7:0] mem_rsp_data;
  logic [VL-1:0] vec_a, vec_b, vec_c;
  logic done, fault, reject;
  logic [IW-1:0] fault_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_deint_load #(.VL_BITS(VL), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_base(start_base), .start_imm(start_imm), .start_pred(start_pred),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .vec_a(vec_a), .vec_b(vec_b), .vec_c(vec_c), .done(done), .fault(fault),
    .fault_idx(fault_idx), .reject(reject)
  );

  typedef struct {
    int kind; // 0 done, 1 fault, 2 reject
    logic [VL-1:0] a, b, c;
    int idx;
  } ev_t;

  ev_t ev_q[$];
  logic [AW-1:0] addr_q[$];
  logic [VL-1:0] m_a = '0, m_b = '0, m_c = '0;
  int n_chk = 0, n_bad = 0;
  int stall = 0;

  // readable memory below 0x8000_0000, error region at and above it
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic bad_addr(input logic [AW-1:0] a);
    return a[AW-1];
  endfunction

  task automatic check(input bit ok, input string req, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // memory responder: one outstanding request, answer one cycle after accept
  initial begin
    logic pend;
    logic [AW-1:0] pa;
    logic [AW-1:0] ea;
    pend = 1'b0;
    pa = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    mem_rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err = 1'b0;
      mem_req_ready = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_byte(pa);
        mem_rsp_err = bad_addr(pa);
        pend = 1'b0;
      end else if (mem_req_valid && rst_n) begin
        stall++;
        if ((stall % 3) != 2) begin
          mem_req_ready = 1'b1;
          pend = 1'b1;
          pa = mem_req_addr;
          if (addr_q.size() == 0) begin
            check(1'b0, "R3/R8 unexpected request", VL'(mem_req_addr), '0);
          end else begin
            ea = addr_q.pop_front();
            // R2 R5: address and ordering
            check(mem_req_addr == ea, "R2/R5 request address", VL'(mem_req_addr), VL'(ea));
          end
        end
      end
    end
  end

  // monitor: pop expected end events and compare
  initial begin
    ev_t e;
    int k;
    forever begin
      @(negedge clk);
      if (rst_n && (done || fault || reject)) begin
        k = done ? 0 : (fault ? 1 : 2);
        if (ev_q.size() == 0) begin
          check(1'b0, "R7 unexpected end event", VL'(k), '0);
        end else begin
          e = ev_q.pop_front();
          check(k == e.kind, "R6/R7/R9 end event kind", VL'(k), VL'(e.kind));
          // R1 R3 R7: vectors (unchanged for R6 and R9)
          check(vec_a == e.a, "R1/R3/R6/R9 vec_a", vec_a, e.a);
          check(vec_b == e.b, "R1/R3/R6/R9 vec_b", vec_b, e.b);
          check(vec_c == e.c, "R1/R3/R6/R9 vec_c", vec_c, e.c);
          if (e.kind == 1)
            check(int'(fault_idx) == e.idx, "R6 fault_idx", VL'(fault_idx), VL'(e.idx));
        end
      end
    end
  end

  task automatic run_op(input logic [AW-1:0] base, input int imm,
                        input logic [LANES-1:0] pred);
    ev_t e;
    logic [AW-1:0] org, a;
    bit stop;
    e.a = '0; e.b = '0; e.c = '0; e.idx = 0; e.kind = 0;
    stop = 0;
    if (!(imm >= -24 && imm <= 21 && (imm % 3) == 0)) begin
      e.kind = 2;
      e.a = m_a; e.b = m_b; e.c = m_c;
    end else begin
      org = base + AW'(imm * LANES);
      for (int k = 0; k < LANES && !stop; k++) begin
        if (pred[k]) begin
          for (int j = 0; j < 3 && !stop; j++) begin
            a = org + AW'(3 * k + j);
            addr_q.push_back(a);
            if (bad_addr(a)) begin
              stop = 1;
              e.kind = 1;
              e.idx = k;
            end else if (j == 0) e.a[8*k +: 8] = mem_byte(a);
            else if (j == 1) e.b[8*k +: 8] = mem_byte(a);
            else e.c[8*k +: 8] = mem_byte(a);
          end
        end
      end
      if (stop) begin
        e.a = m_a; e.b = m_b; e.c = m_c;
      end
    end
    m_a = e.a; m_b = e.b; m_c = e.c;
    ev_q.push_back(e);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    start_base = base;
    start_imm = 6'(imm);
    start_pred = pred;
    @(negedge clk);
    start_valid = 1'b0;
    while (ev_q.size() != 0) @(negedge clk);
    // R3 R6 R8 R9: every expected request consumed, none left over
    check(addr_q.size() == 0, "R3/R6/R8/R9 request count", VL'(addr_q.size()), '0);
    addr_q.delete();
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    check(1'b0, "watchdog expired", VL'(cyc), '0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(start_ready === 1'b1, "R10 start_ready", VL'(start_ready), VL'(1));
    check({done, fault, reject, mem_req_valid} === 4'b0, "R10 pulses low",
          VL'({done, fault, reject, mem_req_valid}), '0);
    check((vec_a | vec_b | vec_c) === '0, "R10 vectors zero", vec_a | vec_b | vec_c, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(32'h0000_0100, 0, '1);             // R1 all active
    run_op(32'h0000_0200, 3, 16'hA5C3);       // R2 R3 positive imm, mixed predicate
    run_op(32'h0000_1000, -24, 16'h3C0F);     // R2 lowest imm
    run_op(32'h0000_0000, 21, 16'h8001);      // R2 highest imm
    run_op(32'h7FFF_FFF0, 0, 16'h001F);       // R4 inactive lanes on error addresses
    run_op(32'h0000_0300, 0, '0);             // R8 empty predicate
    run_op(32'h0000_0400, 0, 16'hFFFF);       // refill before fault
    run_op(32'h7FFF_FFF0, 0, 16'h0063);       // R6 fault at element 5, second byte
    run_op(32'h0000_0500, 4, 16'hFFFF);       // R9 not multiple of 3
    run_op(32'h0000_0500, 24, 16'hFFFF);      // R9 above range
    run_op(32'h0000_0500, -27, 16'hFFFF);     // R9 below range
    run_op(32'hFFFF_FF00, 0, 16'h0001);       // R6 fault at element 0, first byte
    run_op(32'h0000_0600, -3, 16'h5555);      // R1 R3 after faults
    repeat (4) @(negedge clk);
    check(start_ready === 1'b1, "R10 idle after jobs", VL'(start_ready), VL'(1));
    summary();
  end
endmodule